// File: doc/BRIEF.md
# Memory-Mapped Event Counter Bank

The block is a bank of sixteen 32-bit general event counters and one 56-bit cycle counter. Software reaches them through a simple 32-bit register port that carries a valid, a write flag, a 12-bit byte address and write data. Each general counter watches one bit of a 64-bit vector of single-cycle event strobes. The strobes are synchronous to the block clock. Software picks the bit, and sets a per-counter enable, through select registers that each hold four counters' settings side by side.

One global running flag gates all counting. Software sets or clears it through a control register, and a third control bit clears every counter at once. Software cannot write a counter directly. To load a counter, software first writes a target code into a test-select register, then writes the value into a shared load register. When a general counter rolls over from all ones to zero, it reports this on its own bit of a one-cycle overflow output.

Top module: `evt_cnt_bank`

## Requirements
- R1: After the asynchronous reset, all counters are zero, the running flag is clear, and the select and test-select registers read zero.
- R2: A write to 0xC00 with bit 1 set clears the running flag. If bit 1 is clear and bit 0 is set, the write sets the flag. Stop wins when both bits are set. A read of 0xC00 returns the flag in bit 0 and zeros in bits 31:1.
- R3: General counter n reads at 0xC78 + 4n. It adds exactly one at a clock edge when all of these hold before the edge: the running flag is set, its enable bit is set, and the event strobe at the index held in its event field is high.
- R4: The settings for counter n sit in the 32-bit register at 0xC68 + 4*(n/4), in the byte at bit 8*(n%4). Bit 7 of that byte is the enable and bits 5:0 are the event index. The registers read back as written. A counter whose enable bit is clear holds its value whatever its event strobe does.
- R5: A write to 0xC00 with bit 2 set makes every general counter and the cycle counter zero after that edge, whether the block is running or not.
- R6: The test-select register at 0xC08 is readable. When it holds 19 + n with n in 0..15, a write to 0xC0C loads the write data into counter n, and this load wins over an event in the same cycle. For any other test-select value, including 0, 18 and 35, a write to 0xC0C changes no counter.
- R7: When a counting step takes a general counter from 0xFFFFFFFF to 0, bit n of ovf_o is high for exactly the one cycle after that edge. At all other times it is low.
- R8: The cycle counter adds one on every edge while the running flag is set. Its bits 31:0 read at 0xC14. Its bits 55:32 read at 0xC10 in bits 23:0, with bits 31:24 reading zero.
- R9: A write to a counter address changes no counter. A read of 0xC0C or of any unmapped offset returns zero, and bus_rdata is zero when no read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_vld | input | 1 | Register access present this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as a read access |
| evt_i | input | 64 | Single-cycle event strobes |
| ovf_o | output | 16 | Per-counter wrap pulse |

## Verification
The hardest case to reach from the ports is a wrap. At the rate events arrive, reaching all ones would take billions of cycles. The stimulus therefore uses the two-step load sequence to put counters a few counts below the top, and then drives their selected strobes so that they roll over. The random phase also mixes in loads of values near all ones, and places loads in the same cycle as events, to cover the priority between loading and counting.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int TSEL_BASE = 19;
  localparam logic [ADDR_W-1:0] A_CTRL     = 12'hC00;
  localparam logic [ADDR_W-1:0] A_TSEL     = 12'hC08;
  localparam logic [ADDR_W-1:0] A_PRELOAD  = 12'hC0C;
  localparam logic [ADDR_W-1:0] A_CYC_HI   = 12'hC10;
  localparam logic [ADDR_W-1:0] A_CYC_LO   = 12'hC14;
  localparam logic [ADDR_W-1:0] A_SEL_BASE = 12'hC68;
  localparam logic [ADDR_W-1:0] A_CNT_BASE = 12'hC78;
  localparam int CTRL_START = 0;
  localparam int CTRL_STOP  = 1;
  localparam int CTRL_CLEAR = 2;
endpackage

// File: rtl/ecb_regif.sv
module ecb_regif
  import ecb_pkg::*;
#(
  parameter int NUM_CTR = 16,
  localparam int NSEL = NUM_CTR / 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_vld,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic                     run_o,
  output logic                     clr_o,
  output logic [NUM_CTR-1:0]       ld_o,
  output logic [NSEL*DATA_W-1:0]   sel_regs_o,
  output logic [DATA_W-1:0]        tsel_o
);
  logic wr_en;
  logic ctrl_wr;
  logic run_q, run_d;
  logic [NSEL*DATA_W-1:0] sel_q, sel_d;
  logic [DATA_W-1:0] tsel_q, tsel_d;

  assign wr_en   = bus_vld & bus_wr;
  assign ctrl_wr = wr_en && (bus_addr == A_CTRL);

  always_comb begin
    run_d  = run_q;
    sel_d  = sel_q;
    tsel_d = tsel_q;
    if (ctrl_wr) begin
      if (bus_wdata[CTRL_STOP])       run_d = 1'b0;
      else if (bus_wdata[CTRL_START]) run_d = 1'b1;
    end
    if (wr_en && (bus_addr == A_TSEL)) tsel_d = bus_wdata;
    for (int k = 0; k < NSEL; k++) begin
      if (wr_en && (bus_addr == A_SEL_BASE + ADDR_W'(4 * k)))
        sel_d[k*DATA_W +: DATA_W] = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      sel_q  <= '0;
      tsel_q <= '0;
    end else begin
      run_q  <= run_d;
      sel_q  <= sel_d;
      tsel_q <= tsel_d;
    end
  end

  assign clr_o = ctrl_wr && bus_wdata[CTRL_CLEAR];

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ld
    assign ld_o[n] = wr_en && (bus_addr == A_PRELOAD) &&
                     (tsel_q == DATA_W'(TSEL_BASE + n));
  end

  assign run_o      = run_q;
  assign sel_regs_o = sel_q;
  assign tsel_o     = tsel_q;
endmodule

// File: rtl/ecb_gen_ctr.sv
module ecb_gen_ctr #(
  parameter int CTR_W = 32,
  parameter int EVT_W = 64,
  localparam int IDX_W = $clog2(EVT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [EVT_W-1:0] evt_vec,
  input  logic [IDX_W-1:0] evt_idx,
  input  logic             clr,
  input  logic             ld,
  input  logic [CTR_W-1:0] ld_val,
  output logic [CTR_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic hit;
  logic [CTR_W-1:0] cnt_q, cnt_d;
  logic ovf_q, ovf_d;

  assign hit = cnt_en & evt_vec[evt_idx];

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = 1'b0;
    if (ld)       cnt_d = ld_val;
    else if (clr) cnt_d = '0;
    else if (hit) begin
      cnt_d = cnt_q + 1'b1;
      ovf_d = &cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/ecb_cyc_ctr.sv
module ecb_cyc_ctr #(
  parameter int CYC_W = 56
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  output logic [CYC_W-1:0] cyc_o
);
  logic [CYC_W-1:0] cyc_q, cyc_d;

  always_comb begin
    cyc_d = cyc_q;
    if (clr)      cyc_d = '0;
    else if (run) cyc_d = cyc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cyc_d;
  end

  assign cyc_o = cyc_q;
endmodule

// File: rtl/evt_cnt_bank.sv
module evt_cnt_bank
  import ecb_pkg::*;
#(
  parameter int NUM_CTR = 16,
  parameter int CTR_W   = 32,
  parameter int CYC_W   = 56,
  parameter int EVT_W   = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_vld,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [EVT_W-1:0]   evt_i,
  output logic [NUM_CTR-1:0] ovf_o
);
  localparam int NSEL  = NUM_CTR / 4;
  localparam int IDX_W = $clog2(EVT_W);

  logic run;
  logic clr;
  logic [NUM_CTR-1:0] ld;
  logic [NSEL*DATA_W-1:0] sel_regs;
  logic [DATA_W-1:0] tsel;
  logic [NUM_CTR*CTR_W-1:0] cnt_flat;
  logic [CYC_W-1:0] cyc_cnt;
  logic [DATA_W-1:0] rdata_d;

  ecb_regif #(.NUM_CTR(NUM_CTR)) u_regif (
    .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .run_o(run), .clr_o(clr),
    .ld_o(ld), .sel_regs_o(sel_regs), .tsel_o(tsel)
  );

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
    localparam int BYTE_LSB = (n / 4) * DATA_W + (n % 4) * 8;
    ecb_gen_ctr #(.CTR_W(CTR_W), .EVT_W(EVT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n),
      .cnt_en(run & sel_regs[BYTE_LSB + 7]),
      .evt_vec(evt_i),
      .evt_idx(sel_regs[BYTE_LSB +: IDX_W]),
      .clr(clr), .ld(ld[n]), .ld_val(CTR_W'(bus_wdata)),
      .cnt_o(cnt_flat[n*CTR_W +: CTR_W]), .ovf_o(ovf_o[n])
    );
  end

  ecb_cyc_ctr #(.CYC_W(CYC_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(clr), .cyc_o(cyc_cnt)
  );

  always_comb begin
    rdata_d = '0;
    if (bus_vld && !bus_wr) begin
      if (bus_addr == A_CTRL)   rdata_d = DATA_W'(run);
      if (bus_addr == A_TSEL)   rdata_d = tsel;
      if (bus_addr == A_CYC_HI) rdata_d = DATA_W'(cyc_cnt[CYC_W-1:DATA_W]);
      if (bus_addr == A_CYC_LO) rdata_d = cyc_cnt[DATA_W-1:0];
      for (int k = 0; k < NSEL; k++)
        if (bus_addr == A_SEL_BASE + ADDR_W'(4 * k))
          rdata_d = sel_regs[k*DATA_W +: DATA_W];
      for (int n = 0; n < NUM_CTR; n++)
        if (bus_addr == A_CNT_BASE + ADDR_W'(4 * n))
          rdata_d = DATA_W'(cnt_flat[n*CTR_W +: CTR_W]);
    end
  end

  assign bus_rdata = rdata_d;
endmodule

// File: rtl/ecb_chk.sv
module ecb_chk
  import ecb_pkg::*;
#(
  parameter int NUM_CTR = 16,
  parameter int CTR_W   = 32,
  parameter int CYC_W   = 56
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_vld,
  input logic                     bus_wr,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [2:0]               ctrl_bits,
  input logic                     run_q,
  input logic [CYC_W-1:0]         cyc_cnt,
  input logic [NUM_CTR*CTR_W-1:0] cnt_flat,
  input logic [NUM_CTR-1:0]       ovf_o
);
  logic ctrl_wr;
  logic cnt_region_wr;
  assign ctrl_wr = bus_vld && bus_wr && (bus_addr == A_CTRL);
  assign cnt_region_wr = bus_vld && bus_wr && (bus_addr >= A_CNT_BASE) &&
                         (bus_addr < A_CNT_BASE + ADDR_W'(4 * NUM_CTR));

  // R2
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_bits[1]) |=> !run_q);

  // R5
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_bits[2]) |=> (cyc_cnt == '0) && (cnt_flat == '0));

  // R8
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !(ctrl_wr && ctrl_bits[2])) |=> cyc_cnt == CYC_W'($past(cyc_cnt) + 1'b1));

  // R9
  cnt_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && cnt_region_wr) |=> $stable(cnt_flat));

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ovf
    // R7
    ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o[n] |-> (cnt_flat[n*CTR_W +: CTR_W] == '0));
    // R7
    ovf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o[n] |=> !ovf_o[n]);
  end
endmodule

bind evt_cnt_bank ecb_chk #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .CYC_W(CYC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .ctrl_bits(bus_wdata[2:0]), .run_q(run),
  .cyc_cnt(cyc_cnt), .cnt_flat(cnt_flat), .ovf_o(ovf_o)
);

// File: tb/evt_cnt_bank_tb_top.sv
module evt_cnt_bank_tb_top;
  localparam int CLK_P = 10;
  localparam logic [11:0] O_CTRL = 12'hC00, O_TSEL = 12'hC08, O_LOAD = 12'hC0C,
                          O_CHI = 12'hC10, O_CLO = 12'hC14, O_SEL = 12'hC68, O_CNT = 12'hC78;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_vld, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [63:0] evt_i;
  logic [15:0] ovf_o;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] m_cnt [16];
  logic [55:0] m_cyc;
  logic        m_run;
  logic [31:0] m_sel [4];
  logic [31:0] m_tsel;
  logic [15:0] m_ovf;

  always #(CLK_P/2) clk = ~clk;

  evt_cnt_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_i(evt_i), .ovf_o(ovf_o)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [11:0] a);
    logic [31:0] r;
    r = '0;
    if (a == O_CTRL) r = {31'b0, m_run};
    if (a == O_TSEL) r = m_tsel;
    if (a == O_CHI)  r = {8'b0, m_cyc[55:32]};
    if (a == O_CLO)  r = m_cyc[31:0];
    for (int k = 0; k < 4; k++) if (a == O_SEL + 12'(4*k)) r = m_sel[k];
    for (int n = 0; n < 16; n++) if (a == O_CNT + 12'(4*n)) r = m_cnt[n];
    return r;
  endfunction

  task automatic model_upd(input logic vld, input logic wr, input logic [11:0] a,
                           input logic [31:0] wd, input logic [63:0] ev);
    logic w, clr;
    logic [7:0] b;
    w   = vld && wr;
    clr = w && (a == O_CTRL) && wd[2];
    for (int n = 0; n < 16; n++) begin
      b = m_sel[n/4][8*(n%4) +: 8];
      m_ovf[n] = 1'b0;
      if (w && (a == O_LOAD) && (m_tsel == 32'(19 + n))) m_cnt[n] = wd;
      else if (clr) m_cnt[n] = '0;
      else if (m_run && b[7] && ev[b[5:0]]) begin
        if (m_cnt[n] == 32'hFFFF_FFFF) m_ovf[n] = 1'b1;
        m_cnt[n] = m_cnt[n] + 1;
      end
    end
    if (clr) m_cyc = '0;
    else if (m_run) m_cyc = m_cyc + 1;
    if (w && a == O_CTRL) begin
      if (wd[1]) m_run = 1'b0;
      else if (wd[0]) m_run = 1'b1;
    end
    if (w && a == O_TSEL) m_tsel = wd;
    for (int k = 0; k < 4; k++) if (w && a == O_SEL + 12'(4*k)) m_sel[k] = wd;
  endtask

  task automatic step(input logic vld, input logic wr, input logic [11:0] a,
                      input logic [31:0] wd, input logic [63:0] ev, output logic [31:0] rd);
    @(negedge clk);
    bus_vld = vld; bus_wr = wr; bus_addr = a; bus_wdata = wd; evt_i = ev;
    #1 rd = bus_rdata;
    @(posedge clk);
    model_upd(vld, wr, a, wd, ev);
    #1 chk(64'(ovf_o), 64'(m_ovf), "R7 ovf_o");
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] wd, input logic [63:0] ev);
    logic [31:0] dummy;
    step(1'b1, 1'b1, a, wd, ev, dummy);
  endtask

  task automatic rd(input logic [11:0] a, input logic [63:0] ev, input string tag);
    logic [31:0] exp, got;
    exp = model_read(a);
    step(1'b1, 1'b0, a, 32'h0, ev, got);
    chk(64'(got), 64'(exp), tag);
  endtask

  task automatic idle(input logic [63:0] ev);
    logic [31:0] got;
    step(1'b0, 1'b0, 12'h0, 32'h0, ev, got);
    chk(64'(got), 64'h0, "R9 idle rdata");
  endtask

  function automatic logic [63:0] rnd_evt();
    return {$urandom, $urandom} & {$urandom, $urandom};
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] got;
    void'($urandom(32'd4711));
    for (int n = 0; n < 16; n++) m_cnt[n] = '0;
    for (int k = 0; k < 4; k++) m_sel[k] = '0;
    m_cyc = '0; m_run = 1'b0; m_tsel = '0; m_ovf = '0;
    rst_n = 1'b0; bus_vld = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; evt_i = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(O_CTRL, 64'h0, "R1 ctrl");
    rd(O_CLO, 64'h0, "R1 cyc lo");
    rd(O_TSEL, 64'h0, "R1 tsel");
    for (int k = 0; k < 4; k++) rd(O_SEL + 12'(4*k), 64'h0, "R1 sel");
    for (int n = 0; n < 16; n++) rd(O_CNT + 12'(4*n), 64'h0, "R1 cnt");

    // R4 packed selects: last register disables counters 12..15
    for (int k = 0; k < 3; k++) wr(O_SEL + 12'(4*k), $urandom | 32'h8080_8080, 64'h0);
    wr(O_SEL + 12'hC, $urandom & 32'h7F7F_7F7F, 64'h0);
    for (int k = 0; k < 4; k++) rd(O_SEL + 12'(4*k), 64'h0, "R4 sel readback");

    // R3 random counting while running
    wr(O_CTRL, 32'h1, 64'h0);
    for (int i = 0; i < 400; i++) begin
      if (i % 37 == 5) rd(O_CNT + 12'(4*$urandom_range(0, 15)), rnd_evt(), "R3 live read");
      else idle(rnd_evt());
    end
    wr(O_CTRL, 32'h2, rnd_evt());
    rd(O_CTRL, 64'h0, "R2 stopped");
    for (int n = 0; n < 16; n++) rd(O_CNT + 12'(4*n), {64{1'b1}}, "R3 R4 count");
    for (int n = 12; n < 16; n++) chk(64'(m_cnt[n]), 64'h0, "R4 disabled held");
    rd(O_CLO, 64'h0, "R8 cyc lo");
    rd(O_CHI, 64'h0, "R8 cyc hi");

    // R2 stop wins over start
    wr(O_CTRL, 32'h3, 64'h0);
    rd(O_CTRL, 64'h0, "R2 stop wins");
    wr(O_CTRL, 32'h1, 64'h0);
    rd(O_CTRL, 64'h0, "R2 started");

    // R6 preload via test select; counter 5 watches event 7
    wr(O_SEL + 12'h4, 32'h0000_8700, 64'h0);
    wr(O_TSEL, 32'd24, 64'h0);
    rd(O_TSEL, 64'h0, "R6 tsel readback");
    wr(O_LOAD, 32'hFFFF_FFFD, 64'h0);
    rd(O_CNT + 12'd20, 64'h0, "R6 preloaded");
    // R7 wrap: three events take FFFFFFFD to 0
    for (int i = 0; i < 3; i++) idle(64'h80);
    chk(64'(ovf_o[5]), 64'h1, "R7 wrap pulse");
    idle(64'h0);
    chk(64'(ovf_o[5]), 64'h0, "R7 pulse one cycle");
    rd(O_CNT + 12'd20, 64'h0, "R7 wrapped value");
    // R6 preload wins over a simultaneous event
    wr(O_LOAD, 32'h0000_1000, 64'h80);
    rd(O_CNT + 12'd20, 64'h0, "R6 load over event");
    chk(64'(m_cnt[5]), 64'h1000, "R6 load value");
    // R6 boundary n = 15
    wr(O_TSEL, 32'd34, 64'h0);
    wr(O_LOAD, 32'hABCD_0123, 64'h0);
    rd(O_CNT + 12'd60, 64'h0, "R6 last counter");
    // R6 non-target codes change nothing
    wr(O_CTRL, 32'h2, 64'h0);
    for (int t = 0; t < 3; t++) begin
      wr(O_TSEL, (t == 0) ? 32'd0 : (t == 1) ? 32'd18 : 32'd35, 64'h0);
      wr(O_LOAD, 32'h5555_AAAA, 64'h0);
      for (int n = 0; n < 16; n++) rd(O_CNT + 12'(4*n), 64'h0, "R6 ignored code");
    end

    // R9 counter writes ignored, unmapped reads zero
    wr(O_CNT + 12'd20, 32'hDEAD_BEEF, 64'h0);
    rd(O_CNT + 12'd20, 64'h0, "R9 cnt write ignored");
    chk(64'(m_cnt[5]), 64'h1000, "R9 cnt value kept");
    rd(O_LOAD, 64'h0, "R9 load reads zero");
    rd(12'hC04, 64'h0, "R9 unmapped");
    rd(12'hCB8, 64'h0, "R9 unmapped");
    rd(12'h000, 64'h0, "R9 unmapped");

    // R5 clear while running
    wr(O_CTRL, 32'h1, 64'h0);
    repeat (5) idle(64'h80);
    wr(O_CTRL, 32'h4, 64'h80);
    rd(O_CLO, 64'h0, "R5 cyc cleared");
    chk(64'(m_cyc), 64'h1, "R5 cyc restarts");
    rd(O_CNT + 12'd60, 64'h0, "R5 cnt cleared");

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 11);
      case (op)
        0, 1: rd(O_CNT + 12'(4*$urandom_range(0, 15)), rnd_evt(), "R3 random read");
        2: rd(($urandom_range(0, 1) == 1) ? O_CLO : O_CHI, rnd_evt(), "R8 random read");
        3: rd(($urandom_range(0, 1) == 1) ? O_CTRL : O_TSEL, rnd_evt(), "R2 random read");
        4: rd(12'($urandom_range(0, 4095)), rnd_evt(), "R9 random read");
        5: wr(O_SEL + 12'(4*$urandom_range(0, 3)), $urandom, rnd_evt());
        6: wr(O_TSEL, ($urandom_range(0, 3) != 0) ? 32'(19 + $urandom_range(0, 15)) : $urandom, rnd_evt());
        7: wr(O_LOAD, ($urandom_range(0, 1) == 1) ? (32'hFFFF_FFF0 | 32'($urandom_range(0, 15))) : $urandom, rnd_evt());
        8: wr(O_CTRL, ($urandom_range(0, 5) == 0) ? 32'($urandom_range(0, 7)) : 32'h1, rnd_evt());
        default: idle(rnd_evt());
      endcase
    end
    for (int n = 0; n < 16; n++) rd(O_CNT + 12'(4*n), 64'h0, "R3 final");
    rd(O_CLO, 64'h0, "R8 final");

    finish_run();
  end
endmodule